// File: doc/BRIEF.md
# Tape Transport Load and Rewind Sequencer

This block is the control sequencer of a vacuum-column tape transport. It takes debounced host commands (load to on-line, rewind, rewind with unload, forward), the unit select line, the column interlock switch, the tape-path sensor, the beginning and end tab detectors, a reset button and a power reset. From these it drives relay, tension, reel, capstan and rewind-ramp enables, and it reports ready, on-line, rewinding, unloading, load fault and masked tab flags.

A load runs in two stages. In the first stage the main relay is held on and the columns are tensioned while a bounded hold timer waits for the interlock to close. In the second stage the capstan drives forward until the beginning tab is seen, and then the unit goes on line and ready. A rewind waits a fixed pre-delay before it enables the ramp and finishes in two steps at the beginning tab. It can then continue into an unload. Resets pass through four priority levels. A higher level clears its own group and every group below it. Each lower level also has its own completion source. Servo loops, ramps and the data path lie outside this block. Both delays are cycle counters set by parameters.

Top module: `tape_seq_top`

## Requirements
- R1: While `pwrRst` is high at a clock edge, every state output is low after that edge: tension, onLine, ready, rewinding, unloading, loadFault.
- R2: A `cmdLoad` is accepted when select is high, the unit is idle and off line. On acceptance, tension and relayOn rise after the next edge. An edge that sees the interlock closed while tension is high ends stage 1: tension falls and capFwd rises.
- R3: Tension stays high for at most HOLD_CYC cycles. If the interlock has not closed by the HOLD_CYC-th edge, tension falls and loadFault rises. A closure seen at that same edge takes priority and the load continues. The next accepted load clears loadFault.
- R4: In load stage 2, an edge that sees botTab sets onLine and ready and ends forward drive.
- R5: While on line, capFwd equals cmdFwd AND select AND ready AND onLine AND interlock, combinationally.
- R6: An accepted rewind (cmdRewind or cmdRewUnload, with select high and the unit idle, on line and ready) sets rewinding and clears ready after the next edge. rewRamp rises exactly REW_DLY edges after rewinding rose.
- R7: The first edge that sees botTab after the ramp starts sets stage B, and rewRamp falls. The next edge that sees botTab ends the rewind: rewinding goes low and ready goes high.
- R8: When a rewind that began as cmdRewUnload completes, unloading rises and onLine and ready fall. Unloading clears at the first edge with tapePath low.
- R9: resetBtn, or an open interlock while any state other than load stage 1 is active, clears onLine, ready, load stage B, both rewind stages, unload and load stage 1 at the next edge.
- R10: With the interlock open, capFwd, rewRamp and reelMotion are low in the same cycle, and relayOn is low outside load stage 1.
- R11: botFlag = botTab with no rewind, no load in progress and no eotTab. eotFlag = eotTab with no rewind and no botTab.
- R12: Load and rewind commands that arrive while a load, rewind or unload is in progress are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwrRst | input | 1 | Power reset, synchronous, active high |
| resetBtn | input | 1 | Front reset button |
| select | input | 1 | Unit selected |
| interlock | input | 1 | Column interlock switch closed |
| tapePath | input | 1 | Tape threaded through path |
| botTab | input | 1 | Beginning tab detected |
| eotTab | input | 1 | End tab detected |
| cmdLoad | input | 1 | Load to on-line command |
| cmdRewind | input | 1 | Rewind command |
| cmdRewUnload | input | 1 | Rewind then unload command |
| cmdFwd | input | 1 | Forward motion command |
| relayOn | output | 1 | Main relay enable |
| tension | output | 1 | Load stage 1 column tensioning |
| reelMotion | output | 1 | Reel servo enable |
| capFwd | output | 1 | Capstan forward drive |
| rewRamp | output | 1 | Rewind ramp enable |
| ready | output | 1 | Unit ready |
| onLine | output | 1 | Unit on line |
| rewinding | output | 1 | Rewind in progress |
| unloading | output | 1 | Unload in progress |
| loadFault | output | 1 | Hold timeout during load |
| botFlag | output | 1 | Qualified beginning tab |
| eotFlag | output | 1 | Qualified end tab |

## Verification
The hardest point to reach is the edge where the hold timer expires: the interlock must close at exactly the last edge, one edge late, or anywhere before. The stimulus therefore sweeps the closure edge over every position from the first edge to one past the hold limit, and checks tension and loadFault at every edge. The rewind ramp is also checked edge by edge against the pre-delay while a load command is offered, to show that the load is ignored. A full rewind-and-unload then runs through to the tape-path drop.

// File: rtl/tape_seq_pkg.sv
package tape_seq_pkg;
  typedef struct packed {
    logic holdRun;
    logic dlyRun;
  } tmrStrobe_t;
endpackage

// File: rtl/tape_seq_timers.sv
module tape_seq_timers
  import tape_seq_pkg::*;
#(
  parameter int HOLD_CYC = 64,
  parameter int REW_DLY  = 32
) (
  input  logic       clk,
  input  logic       pwrRst,
  input  tmrStrobe_t strb,
  output logic       holdExp,
  output logic       dlyDone
);
  localparam int HW = $clog2(HOLD_CYC + 1);
  localparam int DW = $clog2(REW_DLY + 1);

  logic [HW-1:0] holdCnt;
  logic [DW-1:0] dlyCnt;

  always_ff @(posedge clk) begin
    if (pwrRst || !strb.holdRun) holdCnt <= '0;
    else if (holdCnt != HW'(HOLD_CYC)) holdCnt <= holdCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (pwrRst || !strb.dlyRun) dlyCnt <= '0;
    else if (dlyCnt != DW'(REW_DLY)) dlyCnt <= dlyCnt + 1'b1;
  end

  assign holdExp = strb.holdRun && (holdCnt == HW'(HOLD_CYC - 1));
  assign dlyDone = strb.dlyRun && (dlyCnt == DW'(REW_DLY));
endmodule

// File: rtl/tape_seq_ctrl.sv
module tape_seq_ctrl
  import tape_seq_pkg::*;
(
  input  logic       clk,
  input  logic       pwrRst,
  input  logic       resetBtn,
  input  logic       select,
  input  logic       interlock,
  input  logic       tapePath,
  input  logic       botTab,
  input  logic       eotTab,
  input  logic       cmdLoad,
  input  logic       cmdRewind,
  input  logic       cmdRewUnload,
  input  logic       cmdFwd,
  input  logic       holdExp,
  input  logic       dlyDone,
  output tmrStrobe_t strb,
  output logic       relayOn,
  output logic       tension,
  output logic       reelMotion,
  output logic       capFwd,
  output logic       rewRamp,
  output logic       ready,
  output logic       onLine,
  output logic       rewinding,
  output logic       unloading,
  output logic       loadFault,
  output logic       botFlag,
  output logic       eotFlag
);
  logic ldA, ldB, onl, rdy, rwdA, rwdB, unl, unlPend, ldFlt;
  logic idle, active, loadGo, rewGo, loadDone, rewDone;
  logic rstL1, rstL2, rstL3, rstL4;

  assign idle     = !(ldA || ldB || rwdA || rwdB || unl);
  assign active   = ldB || onl || rwdA || rwdB || unl;
  assign loadGo   = cmdLoad && select && idle && !onl;
  assign rewGo    = (cmdRewind || cmdRewUnload) && select && idle && onl && rdy;
  assign loadDone = ldB && botTab;
  assign rewDone  = rwdB && botTab;

  // priority cascade: each level clears its group and every level below
  assign rstL1 = resetBtn || (!interlock && active);
  assign rstL2 = rstL1 || loadDone;
  assign rstL3 = rstL2 || rewDone;
  assign rstL4 = rstL3 || holdExp || (unl && !tapePath);

  always_ff @(posedge clk) begin
    if (pwrRst) begin
      ldA <= 1'b0; ldB <= 1'b0; onl <= 1'b0; rdy <= 1'b0;
      rwdA <= 1'b0; rwdB <= 1'b0; unl <= 1'b0; unlPend <= 1'b0;
      ldFlt <= 1'b0;
    end else begin
      if (rstL1) begin onl <= 1'b0; rdy <= 1'b0; end
      if (rstL2) ldB <= 1'b0;
      if (rstL3) begin rwdA <= 1'b0; rwdB <= 1'b0; unlPend <= 1'b0; end
      if (rstL4) begin unl <= 1'b0; ldA <= 1'b0; end
      if (!rstL1) begin
        if (loadGo) begin ldA <= 1'b1; ldFlt <= 1'b0; end
        if (ldA && interlock) begin
          ldA <= 1'b0;
          ldB <= 1'b1;
        end else if (holdExp) begin
          ldFlt <= 1'b1;
        end
        if (loadDone) begin onl <= 1'b1; rdy <= 1'b1; end
        if (rewGo) begin
          rwdA    <= 1'b1;
          rdy     <= 1'b0;
          unlPend <= cmdRewUnload;
        end
        if (rwdA && !rwdB && dlyDone && botTab) rwdB <= 1'b1;
        if (rewDone) begin
          if (unlPend) begin
            unl <= 1'b1; onl <= 1'b0; rdy <= 1'b0;
          end else begin
            rdy <= 1'b1;
          end
        end
      end
    end
  end

  assign strb.holdRun = ldA;
  assign strb.dlyRun  = rwdA;

  assign tension    = ldA;
  assign reelMotion = interlock && (ldB || onl || rwdA || unl);
  assign relayOn    = ldA || reelMotion;
  assign capFwd     = interlock && (ldB || (cmdFwd && select && rdy && onl));
  assign rewRamp    = interlock && rwdA && !rwdB && dlyDone;
  assign ready      = rdy;
  assign onLine     = onl;
  assign rewinding  = rwdA || rwdB;
  assign unloading  = unl;
  assign loadFault  = ldFlt;
  assign botFlag    = botTab && !rewinding && !(ldA || ldB) && !eotTab;
  assign eotFlag    = eotTab && !rewinding && !botTab;
endmodule

// File: rtl/tape_seq_top.sv
module tape_seq_top
  import tape_seq_pkg::*;
#(
  parameter int HOLD_CYC = 64,
  parameter int REW_DLY  = 32
) (
  input  logic clk,
  input  logic pwrRst,
  input  logic resetBtn,
  input  logic select,
  input  logic interlock,
  input  logic tapePath,
  input  logic botTab,
  input  logic eotTab,
  input  logic cmdLoad,
  input  logic cmdRewind,
  input  logic cmdRewUnload,
  input  logic cmdFwd,
  output logic relayOn,
  output logic tension,
  output logic reelMotion,
  output logic capFwd,
  output logic rewRamp,
  output logic ready,
  output logic onLine,
  output logic rewinding,
  output logic unloading,
  output logic loadFault,
  output logic botFlag,
  output logic eotFlag
);
  tmrStrobe_t strb;
  logic holdExp, dlyDone;

  tape_seq_timers #(.HOLD_CYC(HOLD_CYC), .REW_DLY(REW_DLY)) uTmr (
    .clk(clk), .pwrRst(pwrRst), .strb(strb),
    .holdExp(holdExp), .dlyDone(dlyDone)
  );

  tape_seq_ctrl uCtrl (
    .clk(clk), .pwrRst(pwrRst), .resetBtn(resetBtn), .select(select),
    .interlock(interlock), .tapePath(tapePath), .botTab(botTab),
    .eotTab(eotTab), .cmdLoad(cmdLoad), .cmdRewind(cmdRewind),
    .cmdRewUnload(cmdRewUnload), .cmdFwd(cmdFwd),
    .holdExp(holdExp), .dlyDone(dlyDone), .strb(strb),
    .relayOn(relayOn), .tension(tension), .reelMotion(reelMotion),
    .capFwd(capFwd), .rewRamp(rewRamp), .ready(ready), .onLine(onLine),
    .rewinding(rewinding), .unloading(unloading), .loadFault(loadFault),
    .botFlag(botFlag), .eotFlag(eotFlag)
  );
endmodule

// File: rtl/tape_seq_chk.sv
module tape_seq_chk #(
  parameter int HOLD_CYC = 64
) (
  input logic clk,
  input logic pwrRst,
  input logic resetBtn,
  input logic interlock,
  input logic botTab,
  input logic eotTab,
  input logic tension,
  input logic reelMotion,
  input logic capFwd,
  input logic rewRamp,
  input logic ready,
  input logic onLine,
  input logic rewinding,
  input logic unloading,
  input logic loadFault,
  input logic botFlag,
  input logic eotFlag
);
  logic [31:0] tenRun;

  always_ff @(posedge clk) begin
    if (pwrRst || !tension) tenRun <= '0;
    else tenRun <= tenRun + 32'd1;
  end

  a_r1_power_clear: assert property (@(posedge clk)
    pwrRst |=> !tension && !onLine && !ready && !rewinding && !unloading && !loadFault);

  a_r2_stage_exit: assert property (@(posedge clk) disable iff (pwrRst)
    tension && interlock |=> !tension);

  a_r3_hold_bound: assert property (@(posedge clk) disable iff (pwrRst)
    tenRun <= 32'(HOLD_CYC));

  a_r6_no_early_ramp: assert property (@(posedge clk) disable iff (pwrRst)
    $rose(rewinding) |-> !rewRamp);

  a_r6_ramp_in_rewind: assert property (@(posedge clk) disable iff (pwrRst)
    rewRamp |-> rewinding);

  a_r8_unload_offline: assert property (@(posedge clk) disable iff (pwrRst)
    unloading |-> !onLine && !ready);

  a_r9_reset_clears: assert property (@(posedge clk) disable iff (pwrRst)
    resetBtn |=> !onLine && !ready && !rewinding && !unloading && !tension);

  a_r10_motion_interlock: assert property (@(posedge clk) disable iff (pwrRst)
    (capFwd || rewRamp || reelMotion) |-> interlock);

  a_r11_bot_mask: assert property (@(posedge clk) disable iff (pwrRst)
    botFlag |-> botTab && !eotTab && !rewinding && !tension);

  a_r11_eot_mask: assert property (@(posedge clk) disable iff (pwrRst)
    eotFlag |-> eotTab && !botTab && !rewinding);
endmodule

bind tape_seq_top tape_seq_chk #(.HOLD_CYC(HOLD_CYC)) uChk (
  .clk(clk), .pwrRst(pwrRst), .resetBtn(resetBtn), .interlock(interlock),
  .botTab(botTab), .eotTab(eotTab), .tension(tension),
  .reelMotion(reelMotion), .capFwd(capFwd), .rewRamp(rewRamp),
  .ready(ready), .onLine(onLine), .rewinding(rewinding),
  .unloading(unloading), .loadFault(loadFault), .botFlag(botFlag),
  .eotFlag(eotFlag)
);

// File: tb/tape_seq_top_test.sv
module tape_seq_top_test;
  localparam int HOLD = 6;
  localparam int DLY  = 4;

  logic clk = 1'b0;
  logic pwrRst = 1'b1, resetBtn = 1'b0, select = 1'b1, interlock = 1'b0;
  logic tapePath = 1'b1, botTab = 1'b0, eotTab = 1'b0;
  logic cmdLoad = 1'b0, cmdRewind = 1'b0, cmdRewUnload = 1'b0, cmdFwd = 1'b0;
  logic relayOn, tension, reelMotion, capFwd, rewRamp, ready, onLine;
  logic rewinding, unloading, loadFault, botFlag, eotFlag;
  int nRun = 0, nFail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tape_seq_top #(.HOLD_CYC(HOLD), .REW_DLY(DLY)) uut (
    .clk(clk), .pwrRst(pwrRst), .resetBtn(resetBtn), .select(select),
    .interlock(interlock), .tapePath(tapePath), .botTab(botTab),
    .eotTab(eotTab), .cmdLoad(cmdLoad), .cmdRewind(cmdRewind),
    .cmdRewUnload(cmdRewUnload), .cmdFwd(cmdFwd), .relayOn(relayOn),
    .tension(tension), .reelMotion(reelMotion), .capFwd(capFwd),
    .rewRamp(rewRamp), .ready(ready), .onLine(onLine),
    .rewinding(rewinding), .unloading(unloading), .loadFault(loadFault),
    .botFlag(botFlag), .eotFlag(eotFlag)
  );

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic act, logic exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic doLoad();
    interlock = 1'b1;
    cmdLoad = 1'b1; cyc(); cmdLoad = 1'b0;
    cyc();
    botTab = 1'b1; cyc(); botTab = 1'b0;
  endtask

  initial begin
    cyc(); cyc();
    chk("R1 tension", tension, 1'b0);
    chk("R1 onLine", onLine, 1'b0);
    chk("R1 ready", ready, 1'b0);
    chk("R1 loadFault", loadFault, 1'b0);
    pwrRst = 1'b0;
    cyc();

    // sweep the edge at which the interlock closes: 1..HOLD+1
    for (int k = 1; k <= HOLD + 1; k++) begin
      interlock = 1'b0;
      cmdLoad = 1'b1; cyc(); cmdLoad = 1'b0;
      chk("R2 tension up", tension, 1'b1);
      chk("R2 relayOn", relayOn, 1'b1);
      chk("R3 fault cleared by load", loadFault, 1'b0);
      for (int c = 1; c < k; c++) begin
        cyc();
        chk("R3 tension window", tension, (c < HOLD) ? 1'b1 : 1'b0);
        chk("R3 fault flag", loadFault, (c >= HOLD) ? 1'b1 : 1'b0);
      end
      if (k <= HOLD) begin
        interlock = 1'b1; cyc();
        chk("R2 stage1 end", tension, 1'b0);
        chk("R2 stage2 forward", capFwd, 1'b1);
        chk("R3 no fault", loadFault, 1'b0);
        botTab = 1'b1; #1;
        chk("R11 bot masked in load", botFlag, 1'b0);
        cyc();
        chk("R4 onLine", onLine, 1'b1);
        chk("R4 ready", ready, 1'b1);
        chk("R4 forward stop", capFwd, 1'b0);
        chk("R11 bot shown idle", botFlag, 1'b1);
        botTab = 1'b0;
        resetBtn = 1'b1; cyc(); resetBtn = 1'b0;
        chk("R9 button clears onLine", onLine, 1'b0);
        chk("R9 button clears ready", ready, 1'b0);
      end
    end

    // on line again, fault cleared
    doLoad();
    chk("R3 fault cleared", loadFault, 1'b0);
    chk("R4 online", onLine, 1'b1);

    cmdFwd = 1'b1; #1;
    chk("R5 forward", capFwd, 1'b1);
    select = 1'b0; #1;
    chk("R5 deselected", capFwd, 1'b0);
    select = 1'b1; cmdFwd = 1'b0; #1;
    chk("R5 no command", capFwd, 1'b0);

    // rewind from mid-tape
    cmdRewind = 1'b1; cyc(); cmdRewind = 1'b0;
    chk("R6 rewinding", rewinding, 1'b1);
    chk("R6 ready low", ready, 1'b0);
    chk("R6 no ramp yet", rewRamp, 1'b0);
    for (int i = 1; i <= DLY; i++) begin
      if (i == 1) begin cmdLoad = 1'b1; eotTab = 1'b1; end
      cyc();
      cmdLoad = 1'b0;
      chk("R6 ramp timing", rewRamp, (i >= DLY) ? 1'b1 : 1'b0);
      if (i == 1) begin
        chk("R12 load ignored", tension, 1'b0);
        chk("R11 eot masked", eotFlag, 1'b0);
        eotTab = 1'b0;
      end
    end
    botTab = 1'b1; cyc();
    chk("R7 ramp off at B", rewRamp, 1'b0);
    chk("R7 still rewinding", rewinding, 1'b1);
    chk("R11 bot masked rewind", botFlag, 1'b0);
    cyc();
    chk("R7 rewind done", rewinding, 1'b0);
    chk("R7 ready", ready, 1'b1);
    chk("R7 online", onLine, 1'b1);
    botTab = 1'b0;

    // rewind and unload
    cmdRewUnload = 1'b1; cyc(); cmdRewUnload = 1'b0;
    for (int i = 0; i < DLY; i++) cyc();
    chk("R6 ramp unload", rewRamp, 1'b1);
    botTab = 1'b1; cyc(); cyc(); botTab = 1'b0;
    chk("R8 unloading", unloading, 1'b1);
    chk("R8 offline", onLine, 1'b0);
    chk("R8 not ready", ready, 1'b0);
    cmdLoad = 1'b1; cyc(); cmdLoad = 1'b0;
    chk("R12 load ignored unload", tension, 1'b0);
    tapePath = 1'b0; cyc(); tapePath = 1'b1;
    chk("R8 unload ends", unloading, 1'b0);

    // interlock opens while on line
    doLoad();
    cmdFwd = 1'b1; #1;
    chk("R10 forward before", capFwd, 1'b1);
    interlock = 1'b0; #1;
    chk("R10 capFwd", capFwd, 1'b0);
    chk("R10 reelMotion", reelMotion, 1'b0);
    chk("R10 relayOn", relayOn, 1'b0);
    cyc(); cmdFwd = 1'b0;
    chk("R9 interlock clears", onLine, 1'b0);

    // button during rewind
    doLoad();
    cmdRewind = 1'b1; cyc(); cmdRewind = 1'b0;
    resetBtn = 1'b1; cyc(); resetBtn = 1'b0;
    chk("R9 rewind cleared", rewinding, 1'b0);
    chk("R9 online cleared", onLine, 1'b0);

    // tab qualification while idle
    botTab = 1'b1; eotTab = 1'b1; #1;
    chk("R11 bot with eot", botFlag, 1'b0);
    chk("R11 eot with bot", eotFlag, 1'b0);
    botTab = 1'b0; #1;
    chk("R11 eot alone", eotFlag, 1'b1);
    eotTab = 1'b0; #1;
    chk("R11 eot gone", eotFlag, 1'b0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      nRun++; nFail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule